// File: doc/BRIEF.md
# Region-Based Access Permission Checker

This block watches the access tap of a processor pipeline and decides, for every instruction presented on the tap, whether that instruction may run where it is and touch what it touches. The instruction address is sorted into one of a set of code regions. The data address of a load or store is sorted into one of a set of data regions. A permission matrix, with one row for each code region, says which data regions that code may read or write. The same row also says which other code regions control may pass into.

Region bounds are arbitrary: each region has an inclusive base and an exclusive limit, and both may be any address. Boot software programs the bounds and the matrix through a plain register write port and then sets a lock that freezes them until reset. Everything not granted is denied. The check sits beside the pipeline and never holds it. Any denial comes out as a one-cycle violation pulse, one clock after the instruction. The pulse carries the instruction address, the data address, the access direction and the cause.

Top module: `region_perm_chk`

## Requirements
- R1: An instruction address maps to code region k when base_k <= address < limit_k. When regions overlap, the lowest-numbered matching region wins. An address that matches no code region is unmapped, and every valid instruction at an unmapped address raises a flow violation (cause bit 0).
- R2: A data address maps to a data region by the same rule. A data access (data_en_i high) whose data address is unmapped, or that is issued from an unmapped code address, raises a data violation (cause bit 1).
- R3: Bases and limits take any address value with no alignment. The address base-1 and the address limit both fall outside the region, while base and limit-1 fall inside.
- R4: A load (data_we_i=0) from code region c to data region d is allowed only if bit 2*d of row c is set. A store (data_we_i=1) is allowed only if bit 2*d+1 of row c is set. Otherwise a data violation is raised.
- R5: When the code region of a valid instruction differs from the mapped code region of the previous valid instruction p, bit 2*N_DATA+c of row p must be set, or a flow violation is raised. Staying in the same region is never checked. The first instruction after reset has no predecessor, and neither does an instruction that follows an unmapped one.
- R6: After reset every base, limit and matrix bit is zero, so every region is empty and every access is denied.
- R7: A configuration write uses cfg_addr_i[7:6] as the group (0 control, 1 code bounds, 2 data bounds, 3 matrix row). For bounds, cfg_addr_i[5:1] is the region and cfg_addr_i[0] selects base (0) or limit (1). For a matrix row, cfg_addr_i[5:1] is the code region and cfg_wdata_i carries the whole row.
- R8: Writing 1 to bit 0 of the control group sets the lock. While the lock is set, all later writes to the bounds, the matrix or the lock are ignored. Only reset clears the lock.
- R9: The violation output rises in the cycle after the offending instruction and lasts one cycle. It carries that instruction's address, data address, access direction and cause bits {data, flow}.
- R10: Cycles with inst_vld_i low produce no violation, whatever data_en_i and the addresses show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration register address |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| inst_vld_i | input | 1 | Tap carries a valid instruction this cycle |
| inst_addr_i | input | ADDR_W | Instruction address |
| data_en_i | input | 1 | Instruction performs a data access |
| data_we_i | input | 1 | Data access direction, 1 store, 0 load |
| data_addr_i | input | ADDR_W | Data access address |
| viol_o | output | 1 | Violation pulse |
| viol_cause_o | output | 2 | Cause, bit 1 data, bit 0 flow |
| viol_iaddr_o | output | ADDR_W | Instruction address of the violation |
| viol_daddr_o | output | ADDR_W | Data address of the violation |
| viol_we_o | output | 1 | Access direction of the violation |

## Verification
The bench builds the checker with ADDR_W=16, N_CODE=4 and N_DATA=4. This makes the matrix rows 12 bits wide and small enough to sweep completely. Every code region is driven against every data region in both directions, at each region's base, limit-1, limit and base-1. Every ordered pair of code regions is driven as a transition. Two data regions overlap, which exercises the priority rule, and the gaps between code regions exercise the unmapped index. The bench also checks that writes made after the lock change nothing, and that reset both clears the lock and returns the block to deny-all.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int CFG_AW = 8;

  typedef enum logic [1:0] {
    GRP_CTRL = 2'd0,
    GRP_CODE = 2'd1,
    GRP_DATA = 2'd2,
    GRP_PERM = 2'd3
  } cfg_grp_e;

  localparam int CAUSE_FLOW = 0;
  localparam int CAUSE_DATA = 1;
endpackage

// File: rtl/rpc_cfg.sv
module rpc_cfg
  import rpc_pkg::*;
#(
  parameter int AW = 32,
  parameter int NC = 8,
  parameter int ND = 8,
  parameter int DW = 32,
  localparam int ROW_W = 2 * ND + NC
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [CFG_AW-1:0]             addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [NC-1:0][AW-1:0]         code_base_o,
  output logic [NC-1:0][AW-1:0]         code_lim_o,
  output logic [ND-1:0][AW-1:0]         data_base_o,
  output logic [ND-1:0][AW-1:0]         data_lim_o,
  output logic [NC-1:0][ROW_W-1:0]      row_o
);
  logic [NC-1:0][AW-1:0]    cb_q, cl_q;
  logic [ND-1:0][AW-1:0]    db_q, dl_q;
  logic [NC-1:0][ROW_W-1:0] row_q;
  logic                     locked_q;
  logic                     wr_ok;
  cfg_grp_e                 grp;
  logic [4:0]               sel_idx;
  logic                     unused_w;

  assign grp      = cfg_grp_e'(addr_i[7:6]);
  assign sel_idx  = addr_i[5:1];
  assign wr_ok    = we_i && !locked_q;
  assign unused_w = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cb_q     <= '0;
      cl_q     <= '0;
      db_q     <= '0;
      dl_q     <= '0;
      row_q    <= '0;
      locked_q <= 1'b0;
    end else if (wr_ok) begin
      if (grp == GRP_CTRL && wdata_i[0]) locked_q <= 1'b1;
      for (int k = 0; k < NC; k++) begin
        if (sel_idx == 5'(k)) begin
          if (grp == GRP_CODE && !addr_i[0]) cb_q[k] <= wdata_i[AW-1:0];
          if (grp == GRP_CODE &&  addr_i[0]) cl_q[k] <= wdata_i[AW-1:0];
          if (grp == GRP_PERM)               row_q[k] <= wdata_i[ROW_W-1:0];
        end
      end
      for (int k = 0; k < ND; k++) begin
        if (sel_idx == 5'(k)) begin
          if (grp == GRP_DATA && !addr_i[0]) db_q[k] <= wdata_i[AW-1:0];
          if (grp == GRP_DATA &&  addr_i[0]) dl_q[k] <= wdata_i[AW-1:0];
        end
      end
    end
  end

  assign code_base_o = cb_q;
  assign code_lim_o  = cl_q;
  assign data_base_o = db_q;
  assign data_lim_o  = dl_q;
  assign row_o       = row_q;

  // R8
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);

  // R8
  frozen_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(locked_q) |-> ($stable(row_q) && $stable(cb_q) && $stable(cl_q)
                         && $stable(db_q) && $stable(dl_q)));
endmodule

// File: rtl/rpc_region_sel.sv
module rpc_region_sel #(
  parameter int AW = 32,
  parameter int N  = 8,
  localparam int IDX_W = $clog2(N + 1),
  localparam int SW    = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [N-1:0][AW-1:0] base_i,
  input  logic [N-1:0][AW-1:0] lim_i,
  output logic [IDX_W-1:0]     idx_o
);
  // lowest index wins on overlap; N means unmapped
  always_comb begin
    idx_o = IDX_W'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (addr_i >= base_i[k] && addr_i < lim_i[k]) idx_o = IDX_W'(k);
    end
  end

  // R1 R2 R3
  region_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_o != IDX_W'(N)) |-> (addr_i >= base_i[idx_o[SW-1:0]] &&
                              addr_i <  lim_i[idx_o[SW-1:0]]));
endmodule

// File: rtl/region_perm_chk.sv
module region_perm_chk
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_CODE = 8,
  parameter int N_DATA = 8,
  parameter int CFG_DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              inst_vld_i,
  input  logic [ADDR_W-1:0] inst_addr_i,
  input  logic              data_en_i,
  input  logic              data_we_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  output logic              viol_o,
  output logic [1:0]        viol_cause_o,
  output logic [ADDR_W-1:0] viol_iaddr_o,
  output logic [ADDR_W-1:0] viol_daddr_o,
  output logic              viol_we_o
);
  localparam int CIW   = $clog2(N_CODE + 1);
  localparam int DIW   = $clog2(N_DATA + 1);
  localparam int CSW   = $clog2(N_CODE);
  localparam int DSW   = $clog2(N_DATA);
  localparam int ROW_W = 2 * N_DATA + N_CODE;

  logic [N_CODE-1:0][ADDR_W-1:0] code_base, code_lim;
  logic [N_DATA-1:0][ADDR_W-1:0] data_base, data_lim;
  logic [N_CODE-1:0][ROW_W-1:0]  perm_row;

  rpc_cfg #(.AW(ADDR_W), .NC(N_CODE), .ND(N_DATA), .DW(CFG_DW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .code_base_o (code_base),
    .code_lim_o  (code_lim),
    .data_base_o (data_base),
    .data_lim_o  (data_lim),
    .row_o       (perm_row)
  );

  logic [CIW-1:0] ci, prev_q;
  logic [DIW-1:0] di;
  logic           prev_vld_q;

  rpc_region_sel #(.AW(ADDR_W), .N(N_CODE)) u_code_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (inst_addr_i),
    .base_i (code_base),
    .lim_i  (code_lim),
    .idx_o  (ci)
  );

  rpc_region_sel #(.AW(ADDR_W), .N(N_DATA)) u_data_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (data_addr_i),
    .base_i (data_base),
    .lim_i  (data_lim),
    .idx_o  (di)
  );

  logic              code_unm, data_unm, prev_unm;
  logic [ROW_W-1:0]  row_cur, row_prev;
  logic [N_DATA-1:0] rd_v, wr_v;
  logic [N_CODE-1:0] jmp_v;
  logic              flow_bad, data_bad, any_bad;

  assign code_unm = (ci == CIW'(N_CODE));
  assign data_unm = (di == DIW'(N_DATA));
  assign prev_unm = (prev_q == CIW'(N_CODE));
  assign row_cur  = perm_row[ci[CSW-1:0]];
  assign row_prev = perm_row[prev_q[CSW-1:0]];
  assign jmp_v    = row_prev[ROW_W-1 -: N_CODE];

  for (genvar d = 0; d < N_DATA; d++) begin : g_perm
    assign rd_v[d] = row_cur[2*d];
    assign wr_v[d] = row_cur[2*d+1];
  end

  assign flow_bad = code_unm ? 1'b1 :
                    (prev_vld_q && !prev_unm && prev_q != ci && !jmp_v[ci[CSW-1:0]]);
  assign data_bad = data_en_i &&
                    ((code_unm || data_unm) ? 1'b1 :
                     !(data_we_i ? wr_v[di[DSW-1:0]] : rd_v[di[DSW-1:0]]));
  assign any_bad  = inst_vld_i && (flow_bad || data_bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q       <= CIW'(N_CODE);
      prev_vld_q   <= 1'b0;
      viol_o       <= 1'b0;
      viol_cause_o <= '0;
      viol_iaddr_o <= '0;
      viol_daddr_o <= '0;
      viol_we_o    <= 1'b0;
    end else begin
      viol_o <= any_bad;
      if (inst_vld_i) begin
        prev_q     <= ci;
        prev_vld_q <= 1'b1;
      end
      if (any_bad) begin
        viol_cause_o[CAUSE_FLOW] <= flow_bad;
        viol_cause_o[CAUSE_DATA] <= data_bad;
        viol_iaddr_o             <= inst_addr_i;
        viol_daddr_o             <= data_addr_i;
        viol_we_o                <= data_we_i;
      end
    end
  end

  // R10
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(inst_vld_i));

  // R9
  addr_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (viol_iaddr_o == $past(inst_addr_i) && viol_daddr_o == $past(data_addr_i)));

  // R9
  cause_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (viol_cause_o != 2'b00));

  // R2
  data_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && viol_cause_o[CAUSE_DATA]) |-> $past(data_en_i));
endmodule

// File: tb/region_perm_chk_tb.sv
`timescale 1ns/1ps
module region_perm_chk_tb;
  localparam int AW = 16, NC = 4, ND = 4, DW = 32, RW = 2 * ND + NC;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          inst_vld = 1'b0, data_en = 1'b0, data_we = 1'b0;
  logic [AW-1:0] inst_addr = '0, data_addr = '0;
  logic          viol, viol_we;
  logic [1:0]    viol_cause;
  logic [AW-1:0] viol_iaddr, viol_daddr;

  region_perm_chk #(.ADDR_W(AW), .N_CODE(NC), .N_DATA(ND), .CFG_DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .inst_vld_i(inst_vld), .inst_addr_i(inst_addr),
    .data_en_i(data_en), .data_we_i(data_we), .data_addr_i(data_addr),
    .viol_o(viol), .viol_cause_o(viol_cause), .viol_iaddr_o(viol_iaddr),
    .viol_daddr_o(viol_daddr), .viol_we_o(viol_we));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [AW-1:0] m_cb[NC], m_cl[NC], m_db[ND], m_dl[ND];
  logic [RW-1:0] m_row[NC];
  bit m_lock, m_prev_ok;
  int m_prev;

  function automatic logic [AW-1:0] cbase(int k); return AW'(16'h100 * (k + 1) + k * 7 + 1); endfunction
  function automatic logic [AW-1:0] clim(int k);  return cbase(k) + AW'(16'h40 + 3 * k); endfunction
  function automatic logic [AW-1:0] dbase(int k); return (k == 3) ? 16'h1220 : AW'(16'h1000 + 16'h100 * k + 3); endfunction
  function automatic logic [AW-1:0] dlim(int k);  return (k == 3) ? 16'h1330 : dbase(k) + 16'h3E; endfunction

  function automatic logic [RW-1:0] mk_row(int c);
    logic [RW-1:0] r = '0;
    for (int d = 0; d < ND; d++) begin
      r[2*d]   = ((c + d) % 2 == 0);
      r[2*d+1] = ((c * 3 + d) % 4 == 1);
    end
    for (int t = 0; t < NC; t++) r[2*ND+t] = ((c + 2 * t) % 3 != 0);
    return r;
  endfunction

  function automatic int cls_code(logic [AW-1:0] a);
    for (int k = 0; k < NC; k++) if (a >= m_cb[k] && a < m_cl[k]) return k;
    return NC;
  endfunction

  function automatic int cls_data(logic [AW-1:0] a);
    for (int k = 0; k < ND; k++) if (a >= m_db[k] && a < m_dl[k]) return k;
    return ND;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < NC; k++) begin m_cb[k] = '0; m_cl[k] = '0; m_row[k] = '0; end
    for (int k = 0; k < ND; k++) begin m_db[k] = '0; m_dl[k] = '0; end
    m_lock = 0; m_prev_ok = 0; m_prev = NC;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R7 address map: {grp[1:0], idx[4:0], sel}
  task automatic cfg_wr(int grp, int idx, bit sel, logic [DW-1:0] val);
    cfg_we = 1'b1; cfg_addr = {2'(grp), 5'(idx), sel}; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!m_lock) begin
      case (grp)
        0: if (val[0]) m_lock = 1;
        1: if (sel) m_cl[idx] = val[AW-1:0]; else m_cb[idx] = val[AW-1:0];
        2: if (sel) m_dl[idx] = val[AW-1:0]; else m_db[idx] = val[AW-1:0];
        default: m_row[idx] = val[RW-1:0];
      endcase
    end
  endtask

  task automatic configure();
    for (int k = 0; k < NC; k++) begin cfg_wr(1, k, 0, DW'(cbase(k))); cfg_wr(1, k, 1, DW'(clim(k))); end
    for (int k = 0; k < ND; k++) begin cfg_wr(2, k, 0, DW'(dbase(k))); cfg_wr(2, k, 1, DW'(dlim(k))); end
    for (int k = 0; k < NC; k++) cfg_wr(3, k, 0, DW'(mk_row(k)));
  endtask

  task automatic step(logic [AW-1:0] ia, bit de, bit we, logic [AW-1:0] da, string req);
    int cur, d;
    bit ef, ed;
    cur = cls_code(ia);
    ef = (cur == NC) || (m_prev_ok && m_prev != NC && m_prev != cur && !m_row[m_prev][2*ND+cur]);
    ed = 0;
    if (de) begin
      d = cls_data(da);
      if (cur == NC || d == ND) ed = 1;
      else ed = !m_row[cur][2*d + (we ? 1 : 0)];
    end
    inst_vld = 1'b1; inst_addr = ia; data_en = de; data_we = we; data_addr = da;
    @(negedge clk);
    inst_vld = 1'b0; data_en = 1'b0;
    m_prev = cur; m_prev_ok = 1;
    check(req, "viol", 32'(viol), 32'(ef | ed));
    if (ef | ed) begin
      check(req, "cause", 32'(viol_cause), {30'd0, ed, ef});
      check("R9", "iaddr", 32'(viol_iaddr), 32'(ia));
      if (ed) begin
        check("R9", "daddr", 32'(viol_daddr), 32'(da));
        check("R9", "we", 32'(viol_we), 32'(we));
      end
    end
  endtask

  task automatic data_sweep(int c);
    for (int d = 0; d < ND; d++) begin
      logic [AW-1:0] pts[4];
      pts[0] = dbase(d) - 1; pts[1] = dbase(d); pts[2] = dlim(d) - 1; pts[3] = dlim(d);
      for (int p = 0; p < 4; p++)
        for (int w = 0; w < 2; w++) step(cbase(c), 1, w[0], pts[p], "R2 R3 R4");
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R6", "viol in reset", 32'(viol), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 default deny before configuration
    step(cbase(0), 1, 0, dbase(0), "R6");
    step(cbase(1), 0, 0, '0, "R6");

    configure();
    // R1 R3 code boundaries incl. gaps (unmapped)
    for (int c = 0; c < NC; c++) begin
      step(cbase(c) - 1, 0, 0, '0, "R1 R3 R7");
      step(cbase(c),     0, 0, '0, "R1 R3 R7");
      step(clim(c) - 1,  0, 0, '0, "R1 R3 R7");
      step(clim(c),      0, 0, '0, "R1 R3 R7");
    end
    // R2 R4 every code/data pair, both directions
    for (int c = 0; c < NC; c++) data_sweep(c);
    // R5 every ordered pair of code regions
    for (int p = 0; p < NC; p++)
      for (int c = 0; c < NC; c++) begin
        step(cbase(p), 0, 0, '0, "R5");
        step(cbase(c) + 1, 0, 0, '0, "R5");
      end

    // R9 single-cycle pulse, R10 idle cycles ignored
    step(16'h0000, 0, 0, '0, "R9");
    inst_vld = 1'b0; data_en = 1'b1; data_addr = 16'h0000; inst_addr = 16'h0000;
    @(negedge clk);
    check("R9", "pulse width", 32'(viol), 0);
    @(negedge clk);
    check("R10", "no inst_vld", 32'(viol), 0);
    data_en = 1'b0;

    // R8 lock then attempt overwrites
    cfg_wr(0, 0, 0, 32'h1);
    cfg_wr(3, 0, 0, '1);
    cfg_wr(1, 0, 0, 32'h0);
    cfg_wr(1, 0, 1, 32'hFFFF);
    cfg_wr(2, 0, 1, 32'hFFFF);
    data_sweep(0);
    step(cbase(0), 0, 0, '0, "R8");
    step(cbase(0) - 1, 0, 0, '0, "R8");
    for (int c = 0; c < NC; c++) begin
      step(cbase(0), 0, 0, '0, "R8");
      step(cbase(c), 0, 0, '0, "R8");
    end

    // reset clears configuration and lock
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    check("R6", "viol in second reset", 32'(viol), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(cbase(0), 1, 1, dbase(0), "R6");
    cfg_wr(1, 0, 0, DW'(cbase(0)));
    cfg_wr(1, 0, 1, DW'(clim(0)));
    step(cbase(0), 0, 0, '0, "R8");
    step(cbase(0), 1, 0, dbase(0), "R6");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule